// File: doc/BRIEF.md
# Garbage collection victim selector

This block keeps per-block bookkeeping for a small flash array and decides which erase block a reclamation pass should empty. Every page program and every page invalidation is reported to it with a block index and a page offset. For each block it holds a valid-page bitmap, a programmed-page bitmap, a valid-page count, a stale-page count and the time of the most recent program. A free-running tick counter provides that time.

The surrounding controller supplies the current number of free blocks. When that number falls below a threshold, the block raises a reclaim request and starts a scan. The scan visits one block per cycle and selects a victim in one of two ways. The first is a greedy rule that takes the block with the most stale pages. The second is a cost-benefit rule that compares age·(1−u)/(2u) across blocks, where u is the fraction of the block's pages that are still valid.

At the end of the scan a one-cycle pulse presents the victim. The block then lists the victim's valid page offsets in ascending order, one per cycle, so that an external mover can copy them in place order. The copy and the erase are done outside this block.

Top module: `gc_victim_sel`

## Requirements
- R1: `gc_needed` is a register. It is 1 in the cycle after `free_cnt` is below GC_THRESH (default 3) and 0 in the cycle after `free_cnt` is at or above GC_THRESH.
- R2: While `gc_needed` is 1 and no pass is running, a scan starts. It examines one block per cycle, NBLK cycles in total, and then raises `scan_done` for exactly one cycle. `vic_found` and `vic_idx` are meaningful only in that cycle, and `vic_found` is never 1 without `scan_done`.
- R3: With `mode_cb` = 0 (greedy), the victim is the eligible block with the largest stale-page count. On equal counts the lowest block index wins.
- R4: With `mode_cb` = 1 (cost-benefit), the victim is the eligible block with the highest age·(PAGES−v)/v. Here v is the block's valid-page count. Age is the tick value at scan start minus the tick value of the block's last accepted program. The comparison is exact, by cross-multiplication.
- R5: In cost-benefit mode, an eligible block with v = 0 beats every block with v > 0. Among such blocks the lowest index wins.
- R6: A block with no programmed pages (valid count and stale count both 0) is never chosen. If no block is eligible, `scan_done` pulses with `vic_found` = 0.
- R7: Some events are ignored and change no state. An invalidation of a page that is not currently valid is ignored. A program of a page already programmed since reset is ignored, including its timestamp.
- R8: After a `scan_done` with `vic_found` = 1, the victim's valid page offsets appear on `reloc_page` in strictly ascending order. Offsets start in the next cycle and come one per cycle with `reloc_valid` = 1. `reloc_last` marks the final offset. A victim with no valid pages produces no offsets.
- R9: During reset (`rst_n` = 0 at a clock edge), `gc_needed`, `scan_done`, `vic_found` and `reloc_valid` are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Page program event |
| wr_blk | input | $clog2(NBLK) | Block of the programmed page |
| wr_page | input | $clog2(PAGES) | Offset of the programmed page |
| inv_en | input | 1 | Page invalidate event |
| inv_blk | input | $clog2(NBLK) | Block of the invalidated page |
| inv_page | input | $clog2(PAGES) | Offset of the invalidated page |
| free_cnt | input | FREE_W | Current number of free blocks |
| mode_cb | input | 1 | 0 = greedy, 1 = cost-benefit (sampled at scan start) |
| gc_needed | output | 1 | Reclaim request |
| scan_done | output | 1 | One-cycle end-of-scan pulse |
| vic_found | output | 1 | A victim was chosen (with `scan_done`) |
| vic_idx | output | $clog2(NBLK) | Chosen block index (with `scan_done`) |
| reloc_valid | output | 1 | `reloc_page` carries a valid offset of the victim |
| reloc_page | output | $clog2(PAGES) | Page offset to relocate |
| reloc_last | output | 1 | Final offset of the list |

## Verification
The hardest state to reach is one in which the two selection rules disagree, because that needs blocks whose ages and fill levels pull in opposite directions. The stimulus programs the block with the most stale pages first. It then programs a sparser block a little later and waits about a thousand cycles, so that the age terms are close while the (1−u)/u terms differ widely. Under these conditions the greedy and cost-benefit scans name different victims. Further cases come from later single invalidations. One creates an exact tie in stale count. Another, on a freshly programmed and fully invalidated block, gives a block with no valid pages, which must win on cost-benefit despite its small age.

// File: rtl/gcv_pkg.sv
// Shared types for the garbage collection victim selector.
package gcv_pkg;
    // Control states of the scan and relocation sequencer.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2,
        ST_LIST = 2'd3
    } gcv_state_e;
endpackage

// File: rtl/gcv_tick.sv
// Free-running modification-time counter.
// Assumes the selector's run time between resets is interpreted modulo 2**TS_W.
module gcv_tick #(
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] now
);
    // Advance one tick per clock, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) now <= '0;
        else        now <= now + 1'b1;
    end
endmodule

// File: rtl/gcv_blk_meta.sv
// Metadata for one erase block: valid and programmed bitmaps, valid and
// stale page counts, and the tick of the last accepted program.
// Assumes at most one program and one invalidate per cycle for this block.
module gcv_blk_meta #(
    parameter int PAGES = 8,
    parameter int TS_W  = 16,
    localparam int PW   = $clog2(PAGES),
    localparam int CW   = $clog2(PAGES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [PW-1:0]    wr_page,
    input  logic             inv_hit,
    input  logic [PW-1:0]    inv_page,
    input  logic [TS_W-1:0]  now,
    output logic [PAGES-1:0] valid_map,
    output logic [CW-1:0]    vcnt,
    output logic [CW-1:0]    icnt,
    output logic [TS_W-1:0]  ts
);
    logic [PAGES-1:0] used_map;
    logic             wr_ok;
    logic             inv_ok;
    logic [PAGES-1:0] valid_nxt;

    // Accept only programs of unused pages and invalidations of valid pages.
    always_comb begin
        wr_ok     = wr_hit && !used_map[wr_page];
        inv_ok    = inv_hit && valid_map[inv_page];
        valid_nxt = valid_map;
        if (wr_ok)  valid_nxt[wr_page]  = 1'b1;
        if (inv_ok) valid_nxt[inv_page] = 1'b0;
    end

    // Hold bitmaps, counters and the last-program tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_map  <= '0;
            valid_map <= '0;
            vcnt      <= '0;
            icnt      <= '0;
            ts        <= '0;
        end else begin
            valid_map <= valid_nxt;
            vcnt      <= vcnt + CW'(wr_ok) - CW'(inv_ok);
            icnt      <= icnt + CW'(inv_ok);
            if (wr_ok) begin
                used_map[wr_page] <= 1'b1;
                ts                <= now;
            end
        end
    end
endmodule

// File: rtl/gcv_scan.sv
// Sequential victim scan (one block per cycle) followed by the ordered
// listing of the victim's valid page offsets.
// Assumes metadata arrays are live; age uses the tick captured at scan start.
module gcv_scan
    import gcv_pkg::*;
#(
    parameter int NBLK  = 8,
    parameter int PAGES = 8,
    parameter int TS_W  = 16,
    localparam int BW   = $clog2(NBLK),
    localparam int PW   = $clog2(PAGES),
    localparam int CW   = $clog2(PAGES + 1),
    localparam int PRW  = TS_W + 2 * CW
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       gc_needed,
    input  logic                       mode_cb,
    input  logic [TS_W-1:0]            now,
    input  logic [NBLK-1:0][PAGES-1:0] vmap_all,
    input  logic [NBLK-1:0][CW-1:0]    vcnt_all,
    input  logic [NBLK-1:0][CW-1:0]    icnt_all,
    input  logic [NBLK-1:0][TS_W-1:0]  ts_all,
    output logic                       scan_done,
    output logic                       vic_found,
    output logic [BW-1:0]              vic_idx,
    output logic                       reloc_valid,
    output logic [PW-1:0]              reloc_page,
    output logic                       reloc_last
);
    localparam logic [CW-1:0] PG = CW'(PAGES);

    gcv_state_e       state;
    logic [BW-1:0]    idx;
    logic             mode_l;
    logic [TS_W-1:0]  scan_now;
    logic             have;
    logic [BW-1:0]    best_idx;
    logic [CW-1:0]    best_v;
    logic [CW-1:0]    best_i;
    logic [TS_W-1:0]  best_age;
    logic [PAGES-1:0] snap;

    logic [CW-1:0]    c_v;
    logic [CW-1:0]    c_i;
    logic [TS_W-1:0]  c_age;
    logic             c_elig;
    logic [PRW-1:0]   lhs;
    logic [PRW-1:0]   rhs;
    logic             beats;
    logic             take;
    logic [PW-1:0]    first;
    logic [PAGES-1:0] cleared;

    // Score the block under scan against the best one held so far.
    always_comb begin
        c_v    = vcnt_all[idx];
        c_i    = icnt_all[idx];
        c_age  = scan_now - ts_all[idx];
        c_elig = (c_v != '0) || (c_i != '0);
        lhs    = PRW'(c_age) * PRW'(PG - c_v) * PRW'(best_v);
        rhs    = PRW'(best_age) * PRW'(PG - best_v) * PRW'(c_v);
        if (!have)               beats = 1'b1;
        else if (!mode_l)        beats = c_i > best_i;
        else if (best_v == '0)   beats = 1'b0;
        else if (c_v == '0)      beats = 1'b1;
        else                     beats = lhs > rhs;
        take = c_elig && beats;
    end

    // Lowest set bit of the snapshot and the snapshot without it.
    always_comb begin
        first = '0;
        for (int i = PAGES - 1; i >= 0; i--) begin
            if (snap[i]) first = PW'(i);
        end
        cleared        = snap;
        cleared[first] = 1'b0;
    end

    // Sequencer: idle, scan every block, present victim, list its pages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            idx      <= '0;
            mode_l   <= 1'b0;
            scan_now <= '0;
            have     <= 1'b0;
            best_idx <= '0;
            best_v   <= '0;
            best_i   <= '0;
            best_age <= '0;
            snap     <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (gc_needed) begin
                        state    <= ST_SCAN;
                        idx      <= '0;
                        have     <= 1'b0;
                        mode_l   <= mode_cb;
                        scan_now <= now;
                    end
                end
                ST_SCAN: begin
                    if (take) begin
                        have     <= 1'b1;
                        best_idx <= idx;
                        best_v   <= c_v;
                        best_i   <= c_i;
                        best_age <= c_age;
                    end
                    if (idx == BW'(NBLK - 1)) state <= ST_DONE;
                    else                      idx   <= idx + 1'b1;
                end
                ST_DONE: begin
                    snap  <= vmap_all[best_idx];
                    state <= (have && vmap_all[best_idx] != '0) ? ST_LIST : ST_IDLE;
                end
                default: begin
                    snap <= cleared;
                    if (cleared == '0) state <= ST_IDLE;
                end
            endcase
        end
    end

    assign scan_done   = (state == ST_DONE);
    assign vic_found   = (state == ST_DONE) && have;
    assign vic_idx     = best_idx;
    assign reloc_valid = (state == ST_LIST);
    assign reloc_page  = first;
    assign reloc_last  = (state == ST_LIST) && (cleared == '0);
endmodule

// File: rtl/gc_victim_sel.sv
// Top: event decode into per-block metadata, reclaim trigger, tick counter
// and the victim scan. Assumes block and page indices are in range.
module gc_victim_sel #(
    parameter int NBLK      = 8,
    parameter int PAGES     = 8,
    parameter int TS_W      = 16,
    parameter int FREE_W    = 8,
    parameter int GC_THRESH = 3,
    localparam int BW       = $clog2(NBLK),
    localparam int PW       = $clog2(PAGES),
    localparam int CW       = $clog2(PAGES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BW-1:0]     wr_blk,
    input  logic [PW-1:0]     wr_page,
    input  logic              inv_en,
    input  logic [BW-1:0]     inv_blk,
    input  logic [PW-1:0]     inv_page,
    input  logic [FREE_W-1:0] free_cnt,
    input  logic              mode_cb,
    output logic              gc_needed,
    output logic              scan_done,
    output logic              vic_found,
    output logic [BW-1:0]     vic_idx,
    output logic              reloc_valid,
    output logic [PW-1:0]     reloc_page,
    output logic              reloc_last
);
    logic [TS_W-1:0]            now;
    logic [NBLK-1:0][PAGES-1:0] vmap_all;
    logic [NBLK-1:0][CW-1:0]    vcnt_all;
    logic [NBLK-1:0][CW-1:0]    icnt_all;
    logic [NBLK-1:0][TS_W-1:0]  ts_all;

    // Raise the reclaim request while free blocks are below threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) gc_needed <= 1'b0;
        else        gc_needed <= free_cnt < FREE_W'(GC_THRESH);
    end

    gcv_tick #(.TS_W(TS_W)) u_tick (.clk(clk), .rst_n(rst_n), .now(now));

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        gcv_blk_meta #(.PAGES(PAGES), .TS_W(TS_W)) u_meta (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (wr_en && (wr_blk == BW'(b))),
            .wr_page  (wr_page),
            .inv_hit  (inv_en && (inv_blk == BW'(b))),
            .inv_page (inv_page),
            .now      (now),
            .valid_map(vmap_all[b]),
            .vcnt     (vcnt_all[b]),
            .icnt     (icnt_all[b]),
            .ts       (ts_all[b])
        );
    end

    gcv_scan #(.NBLK(NBLK), .PAGES(PAGES), .TS_W(TS_W)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .gc_needed  (gc_needed),
        .mode_cb    (mode_cb),
        .now        (now),
        .vmap_all   (vmap_all),
        .vcnt_all   (vcnt_all),
        .icnt_all   (icnt_all),
        .ts_all     (ts_all),
        .scan_done  (scan_done),
        .vic_found  (vic_found),
        .vic_idx    (vic_idx),
        .reloc_valid(reloc_valid),
        .reloc_page (reloc_page),
        .reloc_last (reloc_last)
    );
endmodule

// File: rtl/gcv_checker.sv
// Port-level temporal checks for gc_victim_sel, attached by bind.
module gcv_checker #(
    parameter int NBLK      = 8,
    parameter int PAGES     = 8,
    parameter int FREE_W    = 8,
    parameter int GC_THRESH = 3,
    localparam int BW       = $clog2(NBLK),
    localparam int PW       = $clog2(PAGES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [FREE_W-1:0] free_cnt,
    input logic              gc_needed,
    input logic              scan_done,
    input logic              vic_found,
    input logic [BW-1:0]     vic_idx,
    input logic              reloc_valid,
    input logic [PW-1:0]     reloc_page,
    input logic              reloc_last
);
    assert_gc_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (gc_needed == $past(free_cnt < FREE_W'(GC_THRESH))));

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> !scan_done);

    assert_found_with_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vic_found |-> scan_done);

    assert_list_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reloc_valid && !$past(reloc_valid)) |-> ($past(scan_done) && $past(vic_found)));

    assert_list_ascending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reloc_valid && $past(reloc_valid) && !$past(reloc_last)) |-> (reloc_page > $past(reloc_page)));

    assert_list_not_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reloc_valid |-> !scan_done);

    assert_reset_quiet_R9: assert property (@(posedge clk)
        !rst_n |=> (!gc_needed && !scan_done && !vic_found && !reloc_valid));

    // The victim index is not examined outside the done pulse.
    logic unused_ok;
    assign unused_ok = ^vic_idx;
endmodule

bind gc_victim_sel gcv_checker #(
    .NBLK(NBLK), .PAGES(PAGES), .FREE_W(FREE_W), .GC_THRESH(GC_THRESH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .free_cnt   (free_cnt),
    .gc_needed  (gc_needed),
    .scan_done  (scan_done),
    .vic_found  (vic_found),
    .vic_idx    (vic_idx),
    .reloc_valid(reloc_valid),
    .reloc_page (reloc_page),
    .reloc_last (reloc_last)
);

// File: tb/tb_gc_victim_sel.sv
// Bench for gc_victim_sel: vector table walk, then directed corner tests.
module tb_gc_victim_sel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, inv_en = 1'b0, mode_cb = 1'b0;
    logic [2:0] wr_blk = '0, inv_blk = '0, wr_page = '0, inv_page = '0;
    logic [7:0] free_cnt = 8'd10;
    logic       gc_needed, scan_done, vic_found, reloc_valid, reloc_last;
    logic [2:0] vic_idx, reloc_page;

    int n_chk = 0, n_bad = 0;
    int got_gc, got_done, got_found, got_vic, got_n;
    int got_pg [8];

    always #5 clk = ~clk;

    gc_victim_sel dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_blk(wr_blk), .wr_page(wr_page),
        .inv_en(inv_en), .inv_blk(inv_blk), .inv_page(inv_page), .free_cnt(free_cnt),
        .mode_cb(mode_cb), .gc_needed(gc_needed), .scan_done(scan_done),
        .vic_found(vic_found), .vic_idx(vic_idx), .reloc_valid(reloc_valid),
        .reloc_page(reloc_page), .reloc_last(reloc_last)
    );

    // {mode, free_cnt, expect_gc, expect_victim}
    localparam logic [12:0] VEC [6] = '{
        {1'b0, 8'd5, 1'b0, 3'd0},
        {1'b0, 8'd3, 1'b0, 3'd0},
        {1'b0, 8'd2, 1'b1, 3'd2},
        {1'b1, 8'd2, 1'b1, 3'd1},
        {1'b0, 8'd0, 1'b1, 3'd2},
        {1'b1, 8'd1, 1'b1, 3'd1}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_wr(input int b, input int p);
        @(negedge clk);
        wr_en = 1'b1; wr_blk = 3'(b); wr_page = 3'(p);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_inv(input int b, input int p);
        @(negedge clk);
        inv_en = 1'b1; inv_blk = 3'(b); inv_page = 3'(p);
        @(negedge clk);
        inv_en = 1'b0;
    endtask

    // Drop free count, capture the first victim and its page list, restore.
    task automatic run_gc(input logic m, input logic [7:0] f);
        @(negedge clk);
        mode_cb = m; free_cnt = f;
        got_done = 0; got_found = 0; got_vic = 0; got_n = 0; got_gc = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (k == 0) got_gc = int'(gc_needed);
            if (scan_done) begin
                got_done = 1; got_found = int'(vic_found); got_vic = int'(vic_idx);
                break;
            end
        end
        if (got_done == 1) begin
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (reloc_valid) begin
                    got_pg[got_n] = int'(reloc_page);
                    got_n++;
                    if (reloc_last) break;
                end
            end
        end
        free_cnt = 8'd10;
        repeat (30) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R9: reset state
        chk("R9 gc_needed in reset", int'(gc_needed), 0);
        chk("R9 scan_done in reset", int'(scan_done), 0);
        chk("R9 reloc_valid in reset", int'(reloc_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R6: nothing programmed, no victim
        run_gc(1'b0, 8'd0);
        chk("R6 scan ends with empty array", got_done, 1);
        chk("R6 no victim among free blocks", got_found, 0);
        chk("R6 no offsets listed", got_n, 0);

        // Build metadata: block 2 oldest, then block 1, then block 0
        for (int p = 0; p < 8; p++) do_wr(2, p);
        for (int p = 0; p < 6; p++) do_wr(1, p);
        for (int p = 0; p < 8; p++) do_wr(0, p);
        do_inv(0, 1); do_inv(0, 4);
        do_inv(1, 0); do_inv(1, 2); do_inv(1, 3); do_inv(1, 5);
        for (int p = 0; p < 5; p++) do_inv(2, p);
        repeat (1000) @(negedge clk);

        // Vector table: R1 trigger, R3 greedy, R4 cost-benefit
        foreach (VEC[i]) begin
            run_gc(VEC[i][12], VEC[i][11:4]);
            chk("R1 gc_needed after free count", got_gc, int'(VEC[i][3]));
            chk("R2 scan completion", got_done, int'(VEC[i][3]));
            if (VEC[i][3]) chk(VEC[i][12] ? "R4 cost-benefit victim" : "R3 greedy victim",
                               got_vic, int'(VEC[i][2:0]));
        end

        // R8: ordered list of greedy victim (block 2: pages 5,6,7)
        run_gc(1'b0, 8'd1);
        chk("R8 list length block2", got_n, 3);
        chk("R8 first offset", got_pg[0], 5);
        chk("R8 second offset", got_pg[1], 6);
        chk("R8 third offset", got_pg[2], 7);

        // R8: cost-benefit victim block 1, pages 1,4
        run_gc(1'b1, 8'd1);
        chk("R4 victim block1", got_vic, 1);
        chk("R8 list length block1", got_n, 2);
        chk("R8 first offset block1", got_pg[0], 1);
        chk("R8 second offset block1", got_pg[1], 4);

        // R7: re-invalidate stale page; greedy must still pick block 2
        do_inv(1, 0);
        // R7: program an already programmed page of block 2
        do_wr(2, 0);
        run_gc(1'b0, 8'd2);
        chk("R7 repeated invalidate ignored", got_vic, 2);
        chk("R7 reprogram ignored, list length", got_n, 3);
        chk("R7 reprogram ignored, first offset", got_pg[0], 5);

        // R3 tie: block 1 reaches 5 stale pages, lowest index wins
        do_inv(1, 1);
        run_gc(1'b0, 8'd2);
        chk("R3 tie goes to lowest index", got_vic, 1);
        chk("R8 single offset count", got_n, 1);
        chk("R8 single offset value", got_pg[0], 4);

        // R5: fresh block 3 with no valid pages wins cost-benefit
        do_wr(3, 0); do_wr(3, 1);
        do_inv(3, 0); do_inv(3, 1);
        run_gc(1'b1, 8'd0);
        chk("R5 zero-valid block wins", got_vic, 3);
        chk("R5 victim found", got_found, 1);
        chk("R8 no offsets for empty victim", got_n, 0);
        run_gc(1'b0, 8'd0);
        chk("R3 greedy ignores young empty block", got_vic, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule